// File: doc/BRIEF.md
# Integer Subset Decode and Address Unit

This block takes one 32-bit instruction word at a time and works out what a small integer subset asks for. The subset is add immediate, OR, load word and zero, store word, store word with update, and branch conditional to link. Bits are numbered from the most significant end, so instruction bit 0 is `issue_instr[31]` and bit 31 is `issue_instr[0]`. The block pulls out the register and immediate fields and drives two register-file read indices. It takes the 64-bit read data back and returns a one-hot instruction class, the register write index and enable, memory read or write strobes, a 64-bit ALU result or effective address, the 32-bit store data and an illegal-instruction flag. The register file, the memory and branch evaluation sit outside the block.

A small sequencer controls the block. It has three states, `S_IDLE`, `S_READ` and `S_DONE`. Transition *accept* (`S_IDLE` to `S_READ`) occurs when `issue_valid` is high in `S_IDLE`, and latches the word. Transition *capture* (`S_READ` to `S_DONE`) is unconditional: the read data present during `S_READ` is combined and the results are registered. Transition *retire* (`S_DONE` to `S_IDLE`) is unconditional. During `S_READ` the external register file must return `rf_a_data` and `rf_b_data` combinationally for the indices shown.

Top module: `isd_unit`

## Requirements
- R1: The primary opcode is instruction bits 0..5. The encodings are: 001110 add immediate (class bit 0), 100000 load word and zero (class bit 2), 100100 store word (class bit 3) and 100101 store word with update (class bit 4). While `done` is high, `cls` has exactly one bit set for a legal word.
- R2: Primary opcode 011111 is OR (class bit 1) only when bits 21..30 equal 0110111100. Primary opcode 010011 is branch conditional to link (class bit 5) only when bits 21..30 equal 0000010000. Any other extended value is illegal.
- R3: A word that matches none of the encodings sets `illegal` and leaves `cls` at zero. It also keeps `gpr_we`, `mem_rd` and `mem_wr` low.
- R4: For add immediate, load and store word, an RA field (bits 11..15) of 0 gives a base of zero instead of the content of register 0. A nonzero RA gives the content of that register as the base.
- R5: Add immediate returns base plus the sign-extended 16-bit immediate (bits 16..31). It writes the result to the register named by bits 6..10.
- R6: OR returns the bitwise OR of the registers named by bits 6..10 and bits 16..20. It writes the result to the register named by RA.
- R7: Store word raises `mem_wr` at address base plus the sign-extended displacement. `st_data` is the low 32 bits of the register named by bits 6..10, and no register is written.
- R8: Store word with update always takes register RA as the base. It raises `mem_wr` and writes the effective address back into RA. If RA is 0 the word is illegal.
- R9: Load word and zero raises `mem_rd` at address base plus the sign-extended displacement. It names the register in bits 6..10 as the write target with `gpr_we` high, and never raises `mem_rd` and `mem_wr` together.
- R10: A word is accepted only in `S_IDLE`, and `busy` is high while the word is in flight. `done` is high for exactly one cycle, two clock edges after the accepting edge.
- R11: After reset the unit is in `S_IDLE` with `busy`, `done`, `gpr_we`, `mem_rd` and `mem_wr` low.
- R12: Branch conditional to link writes nothing and accesses no memory. It reports bit 31 of the word on `link`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Offers `issue_instr`; taken in `S_IDLE` |
| issue_instr | input | 32 | Instruction word, bit 0 at the MSB |
| busy | output | 1 | A word is being processed |
| rf_a_idx | output | 5 | Read index A (RS for OR, else RA) |
| rf_b_idx | output | 5 | Read index B (RB for OR, else the bits 6..10 register) |
| rf_a_data | input | 64 | Register-file data for index A |
| rf_b_data | input | 64 | Register-file data for index B |
| done | output | 1 | Results valid this cycle |
| cls | output | 6 | One-hot instruction class |
| illegal | output | 1 | Word matched no encoding |
| gpr_we | output | 1 | Register write enable |
| gpr_widx | output | 5 | Register write index |
| mem_rd | output | 1 | Load request |
| mem_wr | output | 1 | Store request |
| result | output | 64 | ALU result or effective address |
| st_data | output | 32 | Store data |
| link | output | 1 | Link bit of a branch to link |

## Verification
The assertions assume that `issue_valid` is ignored outside `S_IDLE`. They also assume that read data is valid and stable throughout `S_READ`. The bench keeps to this by offering a word only when `busy` is low and by returning read data combinationally from its own register array, which does not change during a run. The stimulus mixes random words from a fixed seed, random fields on each legal opcode and OR words with a corrupted extended opcode. Directed cases cover a zero RA, negative displacements, store with update with RA of 0 and the link bit.

// File: rtl/isd_pkg.sv
package isd_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_READ = 2'd1,
        S_DONE = 2'd2
    } isd_state_e;

    localparam int NCLS   = 6;
    localparam int C_ADDI = 0;
    localparam int C_OR   = 1;
    localparam int C_LWZ  = 2;
    localparam int C_STW  = 3;
    localparam int C_STWU = 4;
    localparam int C_BCLR = 5;

    localparam logic [5:0] OP_ADDI = 6'b001110;
    localparam logic [5:0] OP_LWZ  = 6'b100000;
    localparam logic [5:0] OP_STW  = 6'b100100;
    localparam logic [5:0] OP_STWU = 6'b100101;
    localparam logic [5:0] OP_X31  = 6'b011111;
    localparam logic [5:0] OP_X19  = 6'b010011;
    localparam logic [9:0] XO_OR   = 10'b0110111100;
    localparam logic [9:0] XO_BCLR = 10'b0000010000;

    typedef struct packed {
        logic [NCLS-1:0] cls;
        logic            illegal;
        logic [4:0]      rt;
        logic [4:0]      ra;
        logic [4:0]      rb;
        logic [15:0]     imm;
        logic            lk;
    } dec_t;

endpackage

// File: rtl/isd_decode.sv
module isd_decode
    import isd_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);

    logic [5:0] op;
    logic [9:0] xo;

    assign op = word[31:26];
    assign xo = word[10:1];

    always_comb begin
        dec     = '0;
        dec.rt  = word[25:21];
        dec.ra  = word[20:16];
        dec.rb  = word[15:11];
        dec.imm = word[15:0];
        dec.lk  = word[0];
        case (op)
            OP_ADDI: dec.cls[C_ADDI] = 1'b1;
            OP_LWZ:  dec.cls[C_LWZ]  = 1'b1;
            OP_STW:  dec.cls[C_STW]  = 1'b1;
            OP_STWU: dec.cls[C_STWU] = (word[20:16] != 5'd0);
            OP_X31:  dec.cls[C_OR]   = (xo == XO_OR);
            OP_X19:  dec.cls[C_BCLR] = (xo == XO_BCLR);
            default: dec.cls = '0;
        endcase
        dec.illegal = (dec.cls == '0);
    end

endmodule

// File: rtl/isd_exec.sv
module isd_exec
    import isd_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 16,
    parameter int ST_W  = 32
) (
    input  dec_t            dec,
    input  logic [XLEN-1:0] a_data,
    input  logic [XLEN-1:0] b_data,
    output logic [XLEN-1:0] res,
    output logic [ST_W-1:0] st,
    output logic            we,
    output logic [4:0]      widx,
    output logic            rd,
    output logic            wr
);

    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] sext;
    logic [XLEN-1:0] ea;

    always_comb begin
        base = ((dec.ra == 5'd0) && !dec.cls[C_STWU]) ? '0 : a_data;
        sext = {{EXT_W{dec.imm[IMM_W-1]}}, dec.imm};
        ea   = base + sext;
        res  = dec.cls[C_OR] ? (a_data | b_data) : ea;
        st   = b_data[ST_W-1:0];
        we   = dec.cls[C_ADDI] | dec.cls[C_OR] | dec.cls[C_LWZ] | dec.cls[C_STWU];
        widx = (dec.cls[C_OR] | dec.cls[C_STWU]) ? dec.ra : dec.rt;
        rd   = dec.cls[C_LWZ];
        wr   = dec.cls[C_STW] | dec.cls[C_STWU];
    end

endmodule

// File: rtl/isd_unit.sv
module isd_unit
    import isd_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IW    = 32,
    parameter int IMM_W = 16,
    parameter int ST_W  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic [IW-1:0]   issue_instr,
    output logic            busy,
    output logic [4:0]      rf_a_idx,
    output logic [4:0]      rf_b_idx,
    input  logic [XLEN-1:0] rf_a_data,
    input  logic [XLEN-1:0] rf_b_data,
    output logic            done,
    output logic [NCLS-1:0] cls,
    output logic            illegal,
    output logic            gpr_we,
    output logic [4:0]      gpr_widx,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [XLEN-1:0] result,
    output logic [ST_W-1:0] st_data,
    output logic            link
);

    isd_state_e      state_q, state_d;
    logic [IW-1:0]   ir_q;
    dec_t            dec;
    logic [XLEN-1:0] x_res;
    logic [ST_W-1:0] x_st;
    logic            x_we, x_rd, x_wr;
    logic [4:0]      x_widx;

    isd_decode u_dec (
        .word (ir_q),
        .dec  (dec)
    );

    isd_exec #(.XLEN(XLEN), .IMM_W(IMM_W), .ST_W(ST_W)) u_exec (
        .dec    (dec),
        .a_data (rf_a_data),
        .b_data (rf_b_data),
        .res    (x_res),
        .st     (x_st),
        .we     (x_we),
        .widx   (x_widx),
        .rd     (x_rd),
        .wr     (x_wr)
    );

    assign rf_a_idx = dec.cls[C_OR] ? dec.rt : dec.ra;
    assign rf_b_idx = dec.cls[C_OR] ? dec.rb : dec.rt;
    assign busy     = (state_q != S_IDLE);
    assign done     = (state_q == S_DONE);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (issue_valid) state_d = S_READ;
            S_READ:  state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ir_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && issue_valid) ir_q <= issue_instr;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls      <= '0;
            illegal  <= 1'b0;
            gpr_we   <= 1'b0;
            gpr_widx <= '0;
            mem_rd   <= 1'b0;
            mem_wr   <= 1'b0;
            result   <= '0;
            st_data  <= '0;
            link     <= 1'b0;
        end else if (state_q == S_READ) begin
            cls      <= dec.cls;
            illegal  <= dec.illegal;
            gpr_we   <= x_we;
            gpr_widx <= x_widx;
            mem_rd   <= x_rd;
            mem_wr   <= x_wr;
            result   <= x_res;
            st_data  <= x_st;
            link     <= dec.cls[C_BCLR] & dec.lk;
        end else if (state_q == S_DONE) begin
            cls     <= '0;
            illegal <= 1'b0;
            gpr_we  <= 1'b0;
            mem_rd  <= 1'b0;
            mem_wr  <= 1'b0;
            link    <= 1'b0;
        end
    end

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && issue_valid) |=> ##1 done);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_class_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0(cls));

    p_illegal_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!gpr_we && !mem_rd && !mem_wr && cls == '0));

    p_update_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls[C_STWU]) |-> (gpr_we && mem_wr && gpr_widx != 5'd0));

    p_mem_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(mem_rd && mem_wr));

    p_branch_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls[C_BCLR]) |-> (!gpr_we && !mem_rd && !mem_wr));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!gpr_we && !mem_rd && !mem_wr));

endmodule

// File: tb/isd_unit_bench.sv
module isd_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] issue_instr = '0;
    logic        busy, done, illegal, gpr_we, mem_rd, mem_wr, link;
    logic [4:0]  rf_a_idx, rf_b_idx, gpr_widx;
    logic [63:0] rf_a_data, rf_b_data, result;
    logic [5:0]  cls;
    logic [31:0] st_data;

    logic [63:0] regs [32];
    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    assign rf_a_data = regs[rf_a_idx];
    assign rf_b_data = regs[rf_b_idx];

    isd_unit u_isd_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_instr(issue_instr),
        .busy(busy), .rf_a_idx(rf_a_idx), .rf_b_idx(rf_b_idx),
        .rf_a_data(rf_a_data), .rf_b_data(rf_b_data), .done(done), .cls(cls),
        .illegal(illegal), .gpr_we(gpr_we), .gpr_widx(gpr_widx), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .result(result), .st_data(st_data), .link(link)
    );

    typedef struct packed {
        logic [5:0]  cls;
        logic        ill;
        logic        we;
        logic [4:0]  widx;
        logic        rd;
        logic        wr;
        logic [63:0] res;
        logic [31:0] st;
        logic        lk;
    } exp_t;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] w);
        exp_t e;
        logic [5:0]  op;
        logic [4:0]  rt, ra, rb;
        logic [9:0]  xo;
        logic [63:0] sx, base;
        op = w[31:26]; rt = w[25:21]; ra = w[20:16]; rb = w[15:11]; xo = w[10:1];
        sx   = {{48{w[15]}}, w[15:0]};
        base = (ra == 5'd0) ? 64'd0 : regs[ra];
        e = '0;
        case (op)
            6'b001110: begin e.cls = 6'b000001; e.we = 1; e.widx = rt; e.res = base + sx; end
            6'b100000: begin e.cls = 6'b000100; e.we = 1; e.widx = rt; e.rd = 1; e.res = base + sx; end
            6'b100100: begin e.cls = 6'b001000; e.wr = 1; e.res = base + sx; e.st = regs[rt][31:0]; end
            6'b100101: if (ra != 0) begin
                e.cls = 6'b010000; e.we = 1; e.widx = ra; e.wr = 1;
                e.res = regs[ra] + sx; e.st = regs[rt][31:0];
            end
            6'b011111: if (xo == 10'b0110111100) begin
                e.cls = 6'b000010; e.we = 1; e.widx = ra; e.res = regs[rt] | regs[rb];
            end
            6'b010011: if (xo == 10'b0000010000) begin e.cls = 6'b100000; e.lk = w[0]; end
            default: ;
        endcase
        e.ill = (e.cls == 6'd0);
        return e;
    endfunction

    task automatic run(input logic [31:0] w, input string req);
        exp_t e;
        e = model(w);
        @(negedge clk);
        issue_valid = 1'b1;
        issue_instr = w;
        @(negedge clk);
        issue_valid = 1'b0;
        issue_instr = $urandom;
        chk(busy && !done, "R10 busy/no-done in read", {62'd0, busy, done}, 64'd2);
        @(negedge clk);
        chk(done, "R10 done after two edges", {63'd0, done}, 64'd1);
        chk(cls == e.cls, {req, " cls"}, {58'd0, cls}, {58'd0, e.cls});
        chk(illegal == e.ill, {req, " illegal (R3)"}, {63'd0, illegal}, {63'd0, e.ill});
        chk(gpr_we == e.we && mem_rd == e.rd && mem_wr == e.wr, {req, " enables"},
            {61'd0, gpr_we, mem_rd, mem_wr}, {61'd0, e.we, e.rd, e.wr});
        if (e.we) chk(gpr_widx == e.widx, {req, " write index"}, {59'd0, gpr_widx}, {59'd0, e.widx});
        if (e.we || e.rd || e.wr) chk(result == e.res, {req, " result"}, result, e.res);
        if (e.wr) chk(st_data == e.st, {req, " store data (R7)"}, {32'd0, st_data}, {32'd0, e.st});
        if (e.cls[5]) chk(link == e.lk, {req, " link (R12)"}, {63'd0, link}, {63'd0, e.lk});
        @(negedge clk);
        chk(!done && !busy, "R10 one-cycle done", {62'd0, busy, done}, 64'd0);
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt,
                                       input logic [4:0] ra, input logic [15:0] lo);
        return {op, rt, ra, lo};
    endfunction

    function automatic logic [31:0] mkx(input logic [5:0] op, input logic [4:0] rt, input logic [4:0] ra,
                                        input logic [4:0] rb, input logic [9:0] xo, input logic b31);
        return {op, rt, ra, rb, xo, b31};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5e_0042));
        for (int i = 0; i < 32; i++) regs[i] = {$urandom, $urandom};
        regs[0] = 64'hDEAD_BEEF_0BAD_F00D;
        regs[5] = 64'h0000_0000_0000_1000;
        regs[6] = 64'hFFFF_FFFF_8765_4321;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !gpr_we && !mem_rd && !mem_wr, "R11 reset state",
            {59'd0, busy, done, gpr_we, mem_rd, mem_wr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R11 idle after reset", {62'd0, busy, done}, 64'd0);

        // directed cases
        run(mk(6'b001110, 5'd3, 5'd0, 16'hFFFE), "R4 addi ra0");
        run(mk(6'b001110, 5'd3, 5'd5, 16'h8000), "R5 addi negative");
        run(mk(6'b100000, 5'd7, 5'd0, 16'h0010), "R4 lwz ra0");
        run(mk(6'b100000, 5'd7, 5'd5, 16'hFFF0), "R9 lwz");
        run(mk(6'b100100, 5'd6, 5'd0, 16'h0004), "R4 stw ra0");
        run(mk(6'b100100, 5'd6, 5'd5, 16'hFFFC), "R7 stw");
        run(mk(6'b100101, 5'd6, 5'd5, 16'hFF00), "R8 stwu");
        run(mk(6'b100101, 5'd6, 5'd0, 16'h0004), "R8 stwu ra0 illegal");
        run(mkx(6'b011111, 5'd5, 5'd9, 5'd6, 10'b0110111100, 1'b1), "R6 or");
        run(mkx(6'b011111, 5'd5, 5'd9, 5'd6, 10'b0110111101, 1'b0), "R2 or bad xo");
        run(mkx(6'b010011, 5'd20, 5'd1, 5'd0, 10'b0000010000, 1'b1), "R12 bclr lk1");
        run(mkx(6'b010011, 5'd20, 5'd1, 5'd0, 10'b0000010000, 1'b0), "R12 bclr lk0");
        run(mkx(6'b010011, 5'd20, 5'd1, 5'd0, 10'b0000010001, 1'b1), "R2 bclr bad xo");
        run(32'h0000_0000, "R3 zero word");
        run(32'hFFFF_FFFF, "R3 ones word");

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w;
            logic [5:0]  op;
            int k;
            k = $urandom_range(0, 7);
            w = $urandom;
            case (k)
                0: op = 6'b001110;
                1: op = 6'b100000;
                2: op = 6'b100100;
                3: op = 6'b100101;
                4: begin op = 6'b011111; w[10:1] = 10'b0110111100; end
                5: begin op = 6'b010011; w[10:1] = 10'b0000010000; end
                6: op = w[31:26];
                default: begin op = 6'b011111; w[10:1] = 10'($urandom); end
            endcase
            w[31:26] = op;
            if ($urandom_range(0, 5) == 0) w[20:16] = 5'd0;
            if ($urandom_range(0, 9) == 0) regs[$urandom_range(1, 31)] = {$urandom, $urandom};
            run(w, "R1 random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule